// File: doc/BRIEF.md
# System Clock Source Controller

This block chooses which of three clock sources drives the CPU: an internal high-speed oscillator, a high-speed system clock (crystal or external input), and a low-speed subsystem clock. Each source is modelled as a clock enable with a running indication. The mux is shown as one-hot select lines. Software drives the block through a small register write port. Through it, software can stop or restart the high-speed system clock and the internal oscillator, request a new CPU source, and set the crystal stabilization time. Two status bits report the source that is clocking the CPU right now.

A restarted crystal cannot be used until a stabilization counter has run out. In external-clock mode that wait is skipped. A request to switch to a source that is stopped or not yet stable stays pending until that source is ready. A write that would stop the source now clocking the CPU is refused for that source and sets a sticky error flag. All control and status pins are plain level signals. The write port has no back-pressure: a write with `wr_en` high is taken on that rising edge.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: After reset, the internal oscillator runs and is selected. The high-speed system clock is stopped and not stable. The status is {sub_sel,main_sel}=00, the stabilization setting is 0 and the error flag is 0.
- R2: Status encoding is {sub_sel,main_sel} = 00 for the internal oscillator, 01 for the high-speed system clock and 1x for the subsystem clock (main_sel is driven 0 here). cpu_clk_sel is one-hot: bit0 internal, bit1 high-speed, bit2 subsystem.
- R3: A write to address 0 with data bit0 = 1 stops the high-speed system clock. hs_run and hs_stable are both 0 from the write edge on.
- R4: While the high-speed system clock is the active source, a write setting address 0 bit0 leaves hs_run at 1 and sets stop_err.
- R5: A write to address 0 with data bit1 = 0 restarts the internal oscillator. irc_run is 1 from the write edge on.
- R6: While the internal oscillator is the active source, a write setting address 0 bit1 leaves irc_run at 1 and sets stop_err.
- R7: In crystal mode (ext_mode=0), the write that restarts the high-speed system clock is edge 0. hs_stable becomes 1 at edge 2^(N+8) and not earlier. N is written to address 2 bits[2:0].
- R8: In external-clock mode (ext_mode=1), hs_stable becomes 1 on the same edge at which hs_run becomes 1.
- R9: A source request is written to address 1 bits[1:0]: 0 internal, 1 high-speed, 2 subsystem; code 3 is ignored. The status follows one edge after the request is registered and the source is ready. Until then sel_pending is 1 and the status holds. No switch happens on an edge that carries an address 0 write.
- R10: stop_err is sticky. A write to address 3 with bit0 = 1 clears it. A refused stop on the same edge takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| ext_mode | input | 1 | 1: high-speed system clock is an external input |
| hs_run | output | 1 | High-speed system clock enable |
| irc_run | output | 1 | Internal oscillator enable |
| hs_stable | output | 1 | High-speed system clock usable |
| sub_sel | output | 1 | Status: subsystem clock active |
| main_sel | output | 1 | Status: high-speed system clock active |
| cpu_clk_sel | output | 3 | One-hot glitch-free mux select |
| sel_pending | output | 1 | Requested source not yet active |
| stop_err | output | 1 | Sticky refused-stop flag |

## Verification
These results are due one edge after the write: stop and restart enables, refusals, the error flag, ext-mode stability and a request to a ready source. The status reacts one edge after hs_stable rises. Crystal stability is due exactly 2^(N+8) edges after the restart write. The bench samples on the falling edge. For the crystal count it checks the last edge before the target and the target edge itself. The status is checked both on the edge where stability rises and on the edge after it.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [1:0] {
    SRC_IRC = 2'd0,
    SRC_HS  = 2'd1,
    SRC_SUB = 2'd2
  } clk_src_e;

  localparam logic [1:0] ADDR_STOP = 2'd0;
  localparam logic [1:0] ADDR_REQ  = 2'd1;
  localparam logic [1:0] ADDR_STAB = 2'd2;
  localparam logic [1:0] ADDR_ERR  = 2'd3;
  localparam int unsigned NUM_SRC  = 3;
endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
#(
  parameter int unsigned SET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  clk_src_e         act_src,
  output logic             hs_stop_q,
  output logic             hs_stop_d,
  output logic             irc_stop_q,
  output logic             stop_wr,
  output clk_src_e         req_src,
  output logic [SET_W-1:0] stab_set,
  output logic             err_q
);
  logic hs_bad, irc_bad, req_wr;

  assign stop_wr = wr_en && (wr_addr == ADDR_STOP);
  assign req_wr  = wr_en && (wr_addr == ADDR_REQ) && (wr_data[1:0] != 2'd3);
  // Stop refused for the source now clocking the CPU
  assign hs_bad  = stop_wr && wr_data[0] && !hs_stop_q && (act_src == SRC_HS);
  assign irc_bad = stop_wr && wr_data[1] && !irc_stop_q && (act_src == SRC_IRC);

  always_comb begin
    hs_stop_d = hs_stop_q;
    if (stop_wr && !hs_bad) hs_stop_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_stop_q  <= 1'b1;
      irc_stop_q <= 1'b0;
      req_src    <= SRC_IRC;
      stab_set   <= '0;
      err_q      <= 1'b0;
    end else begin
      hs_stop_q <= hs_stop_d;
      if (stop_wr && !irc_bad) irc_stop_q <= wr_data[1];
      if (req_wr) req_src <= clk_src_e'(wr_data[1:0]);
      if (wr_en && (wr_addr == ADDR_STAB)) stab_set <= wr_data[SET_W-1:0];
      if (hs_bad || irc_bad) err_q <= 1'b1;
      else if (wr_en && (wr_addr == ADDR_ERR) && wr_data[0]) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_stab_cnt.sv
module sysclk_stab_cnt #(
  parameter int unsigned SET_W    = 3,
  parameter int unsigned BASE_EXP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_stop_q,
  input  logic             hs_stop_d,
  input  logic             ext_mode,
  input  logic [SET_W-1:0] stab_set,
  output logic             stable
);
  localparam int unsigned CNT_W = BASE_EXP + (1 << SET_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = (CNT_W'(1) << (BASE_EXP + 32'(stab_set))) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (hs_stop_d) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (hs_stop_q) begin
      cnt    <= '0;
      stable <= ext_mode;
    end else if (ext_mode) begin
      stable <= 1'b1;
    end else if (!stable) begin
      if (cnt == last) stable <= 1'b1;
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sysclk_sel.sv
module sysclk_sel
  import sysclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  clk_src_e             req_src,
  input  logic                 stop_wr,
  input  logic                 irc_stop_q,
  input  logic                 hs_stable,
  output clk_src_e             act_src,
  output logic [NUM_SRC-1:0]   onehot
);
  logic [NUM_SRC-1:0] ready;

  assign ready[SRC_IRC] = !irc_stop_q;
  assign ready[SRC_HS]  = hs_stable;
  assign ready[SRC_SUB] = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_src <= SRC_IRC;
    else if (!stop_wr && (req_src != act_src) && ready[req_src]) act_src <= req_src;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    assign onehot[g] = (act_src == clk_src_e'(g));
  end
endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned SET_W    = 3,
  parameter int unsigned BASE_EXP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       ext_mode,
  output logic       hs_run,
  output logic       irc_run,
  output logic       hs_stable,
  output logic       sub_sel,
  output logic       main_sel,
  output logic [2:0] cpu_clk_sel,
  output logic       sel_pending,
  output logic       stop_err
);
  logic             hs_stop_q, hs_stop_d, irc_stop_q, stop_wr;
  clk_src_e         req_src, act_src;
  logic [SET_W-1:0] stab_set;

  sysclk_regs #(.SET_W(SET_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_src(act_src), .hs_stop_q(hs_stop_q), .hs_stop_d(hs_stop_d),
    .irc_stop_q(irc_stop_q), .stop_wr(stop_wr), .req_src(req_src),
    .stab_set(stab_set), .err_q(stop_err)
  );

  sysclk_stab_cnt #(.SET_W(SET_W), .BASE_EXP(BASE_EXP)) u_stab (
    .clk(clk), .rst_n(rst_n), .hs_stop_q(hs_stop_q), .hs_stop_d(hs_stop_d),
    .ext_mode(ext_mode), .stab_set(stab_set), .stable(hs_stable)
  );

  sysclk_sel u_sel (
    .clk(clk), .rst_n(rst_n), .req_src(req_src), .stop_wr(stop_wr),
    .irc_stop_q(irc_stop_q), .hs_stable(hs_stable), .act_src(act_src),
    .onehot(cpu_clk_sel)
  );

  assign hs_run      = !hs_stop_q;
  assign irc_run     = !irc_stop_q;
  assign sub_sel     = (act_src == SRC_SUB);
  assign main_sel    = (act_src == SRC_HS);
  assign sel_pending = (req_src != act_src);
endmodule

// File: rtl/sysclk_src_ctrl_chk.sv
module sysclk_src_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       ext_mode,
  input logic       hs_run,
  input logic       irc_run,
  input logic       hs_stable,
  input logic       sub_sel,
  input logic       main_sel,
  input logic [2:0] cpu_clk_sel,
  input logic       stop_err
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cpu_clk_sel) == 1);
  // R2
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_sel == {sub_sel, main_sel && !sub_sel, !sub_sel && !main_sel});
  // R3
  stable_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_stable |-> hs_run);
  // R4
  hs_active_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_sel && !sub_sel) |-> (hs_run && hs_stable));
  // R6
  irc_active_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_sel && !main_sel) |-> irc_run);
  // R8
  ext_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_mode) && hs_run) |=> hs_stable || !hs_run);
  // R10
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_err) |-> $past(wr_en && wr_addr == 2'd0));
endmodule

bind sysclk_src_ctrl sysclk_src_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .ext_mode(ext_mode),
  .hs_run(hs_run), .irc_run(irc_run), .hs_stable(hs_stable), .sub_sel(sub_sel),
  .main_sel(main_sel), .cpu_clk_sel(cpu_clk_sel), .stop_err(stop_err)
);

// File: tb/sysclk_src_ctrl_tb.sv
module sysclk_src_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext_mode = 1'b0;
  logic       hs_run, irc_run, hs_stable, sub_sel, main_sel, sel_pending, stop_err;
  logic [2:0] cpu_clk_sel;
  int n_run = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sysclk_src_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_mode(ext_mode), .hs_run(hs_run), .irc_run(irc_run), .hs_stable(hs_stable),
    .sub_sel(sub_sel), .main_sel(main_sel), .cpu_clk_sel(cpu_clk_sel),
    .sel_pending(sel_pending), .stop_err(stop_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irc_run", irc_run, 1);
    chk("R1 hs_run", hs_run, 0);
    chk("R1 hs_stable", hs_stable, 0);
    chk("R1 status", {sub_sel, main_sel}, 0);
    chk("R2 sel irc", cpu_clk_sel, 3'b001);
    chk("R1 err", stop_err, 0);
  endtask

  task automatic t_crystal_n0();
    wr(2'd1, 8'd1);               // request high-speed while stopped
    chk("R9 pending", sel_pending, 1);
    chk("R9 status held", {sub_sel, main_sel}, 0);
    wr(2'd1, 8'd3);               // R9 code 3 ignored
    wr(2'd0, 8'h00);              // restart crystal, edge 0
    chk("R7 not yet", hs_stable, 0);
    repeat (255) @(negedge clk);
    chk("R7 edge 255", hs_stable, 0);
    @(negedge clk);
    chk("R7 edge 256", hs_stable, 1);
    chk("R9 status lag", {sub_sel, main_sel}, 0);
    @(negedge clk);
    chk("R2 status hs", {sub_sel, main_sel}, 1);
    chk("R2 sel hs", cpu_clk_sel, 3'b010);
    chk("R9 no pending", sel_pending, 0);
  endtask

  task automatic t_hs_lock();
    wr(2'd0, 8'h01);
    chk("R4 hs kept", hs_run, 1);
    chk("R4 err set", stop_err, 1);
    wr(2'd3, 8'h01);
    chk("R10 err cleared", stop_err, 0);
  endtask

  task automatic t_irc_cycle();
    wr(2'd0, 8'h02);              // stop irc, legal on hs
    chk("R5 irc stopped", irc_run, 0);
    chk("R5 no err", stop_err, 0);
    wr(2'd1, 8'd0);
    @(negedge clk);
    chk("R9 irc pending", {sub_sel, main_sel}, 1);
    wr(2'd0, 8'h00);              // restart irc
    chk("R5 irc restarted", irc_run, 1);
    chk("R9 no switch on stop write", {sub_sel, main_sel}, 1);
    @(negedge clk);
    chk("R2 status irc", {sub_sel, main_sel}, 0);
  endtask

  task automatic t_stop_hs_irc_lock();
    wr(2'd0, 8'h01);
    chk("R3 hs stopped", hs_run, 0);
    chk("R3 hs unstable", hs_stable, 0);
    wr(2'd0, 8'h03);              // irc stop refused, hs kept stopped
    chk("R6 irc kept", irc_run, 1);
    chk("R6 err set", stop_err, 1);
    chk("R3 hs still stopped", hs_run, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 cleared", stop_err, 0);
  endtask

  task automatic t_ext();
    ext_mode = 1'b1;
    wr(2'd0, 8'h00);
    chk("R8 run", hs_run, 1);
    chk("R8 stable now", hs_stable, 1);
    wr(2'd0, 8'h01);
    ext_mode = 1'b0;
    chk("R3 ext stop", hs_stable, 0);
  endtask

  task automatic t_sub_and_n1();
    wr(2'd1, 8'd2);
    chk("R9 sub pending", sel_pending, 1);
    @(negedge clk);
    chk("R2 sub status", {sub_sel, main_sel}, 2);
    chk("R2 sel sub", cpu_clk_sel, 3'b100);
    wr(2'd0, 8'h03);              // both stops legal on subsystem
    chk("R5 irc off on sub", irc_run, 0);
    chk("R10 no err", stop_err, 0);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h02);              // restart crystal, N=1
    repeat (511) @(negedge clk);
    chk("R7 N1 edge 511", hs_stable, 0);
    @(negedge clk);
    chk("R7 N1 edge 512", hs_stable, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_crystal_n0();
    t_hs_lock();
    t_irc_cycle();
    t_stop_hs_irc_lock();
    t_ext();
    t_sub_and_n1();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule